// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank Tracker

This block watches the control inputs of a DDR SDRAM device: chip select, the three command strobes, the bank address and the address bus. It decodes them into commands on every rising clock edge. It keeps an open/idle flag for each of the four internal banks and marks any command that the current bank state does not allow. It also holds the fields written by the two mode-register loads, and it reports auto-precharge and precharge-all requests as they arrive.

Each decoded command is presented for exactly one clock period, starting at the edge that sampled it. The block reports the command kind, the target bank, and the row or column taken from the address bus. An illegal command is reported and flagged, but it changes neither the bank flags nor the mode fields. A monitor or model can therefore follow a device's state from its command stream alone.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Inputs are sampled only on the rising clock edge. A command's decode appears on `cmdValid`, `cmdKind`, `cmdBank`, `illegal`, `autoPre` and `preAll` from that edge until the next edge. `cmdKind` codes are 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 AUTO REFRESH, 6 LOAD MODE, 7 BURST TERMINATE and 0 none.
- R2: With `csN` high, the inputs decode as deselect whatever the other pins carry. NOP (`{csN,rasN,casN,weN}`=0111) behaves the same way. In both cases `cmdValid` is 0 and no bank flag or mode field changes.
- R3: With `csN` low, `{csN,rasN,casN,weN}` decodes as follows: 0011 ACTIVE, 0101 READ, 0100 WRITE, 0010 PRECHARGE, 0001 AUTO REFRESH, 0000 LOAD MODE, 0110 BURST TERMINATE.
- R4: ACTIVE to an idle bank sets that bank's bit in `bankOpen`, where bit n is bank n. It also captures `addr[ROW_W-1:0]` on `cmdRow`.
- R5: PRECHARGE with `addr[10]`=0 closes only the bank named by `ba` and leaves `preAll` at 0. With `addr[10]`=1 it closes all banks and drives `preAll` to 1. Precharging an idle bank is legal.
- R6: READ or WRITE to an open bank captures `cmdCol` = {`addr[11]`, `addr[9:0]`} and drives `autoPre` = `addr[10]`. When `addr[10]` is 1, the bank is idle from the next edge on.
- R7: ACTIVE to a bank that is already open raises `illegal` and leaves `bankOpen` unchanged.
- R8: READ or WRITE to an idle bank raises `illegal` and leaves `bankOpen` unchanged.
- R9: AUTO REFRESH or LOAD MODE while any bank is open raises `illegal`, and no mode field changes.
- R10: LOAD MODE with `ba`=00 and all banks idle loads the base mode fields. `addr[2:0]` sets the burst length (001 gives 2, 010 gives 4, 011 gives 8), `addr[3]` sets `burstInterleave` and `addr[6:4]` sets `casLat`. Any other burst code raises `illegal` and loads nothing, so `burstLen` only ever holds 2, 4 or 8.
- R11: LOAD MODE with `ba`=01 and all banks idle stores the whole address bus in `extMode`. With `ba`=10 or 11 it raises `illegal` and stores nothing.
- R12: After reset, `bankOpen`, `cmdValid`, `illegal`, `autoPre`, `preAll`, `cmdKind`, `cmdBank`, `cmdRow`, `cmdCol`, `burstInterleave` and `extMode` are 0. `burstLen` is 2 and `casLat` is 010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; rising edge samples |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | ADDR_W (13) | Address bus / mode opcode |
| cmdValid | output | 1 | A command other than deselect/NOP was sampled |
| cmdKind | output | 3 | Decoded command code |
| cmdBank | output | 2 | Bank of the sampled command |
| cmdRow | output | ROW_W (13) | Row of the last legal ACTIVE |
| cmdCol | output | COL_W (11) | Column of the last legal READ/WRITE |
| autoPre | output | 1 | READ/WRITE requested auto precharge |
| preAll | output | 1 | PRECHARGE addressed all banks |
| illegal | output | 1 | Sampled command not allowed in current state |
| bankOpen | output | 4 | Per-bank open flags |
| burstLen | output | 4 | Burst length: 2, 4 or 8 |
| burstInterleave | output | 1 | Stored burst-type bit |
| casLat | output | 3 | Stored CAS latency field |
| extMode | output | ADDR_W (13) | Stored extended mode opcode |

## Verification
The properties assume the control pins are at known levels at every rising edge while reset is released. They also assume the bank-address bits index one of the four tracked banks, so that `bankOpen[ba]` is defined. The stimulus changes pins only at the falling edge and holds every pin at a defined level at all times: it drives NOP between commands and during reset. Illegal sequences (double activate, access to an idle bank, refresh or mode load with a bank open, bad burst codes) are sent on purpose, because flagging them is part of the block's job.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  localparam int NUM_BANKS = 4;
  localparam int BA_W      = 2;

  typedef enum logic [2:0] {
    KIND_NONE = 3'd0,
    KIND_ACT  = 3'd1,
    KIND_RD   = 3'd2,
    KIND_WR   = 3'd3,
    KIND_PRE  = 3'd4,
    KIND_REF  = 3'd5,
    KIND_LMR  = 3'd6,
    KIND_BST  = 3'd7
  } cmdKind_e;

  // strobes from the control decode to the datapath registers
  typedef struct packed {
    logic     valid;
    logic     illegal;
    cmdKind_e kind;
    logic     openBank;
    logic     closeBank;
    logic     closeAll;
    logic     captureRow;
    logic     captureCol;
    logic     loadBase;
    logic     loadExt;
    logic     autoPre;
  } ctrlStrobe_t;

endpackage

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
(
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BA_W-1:0]      ba,
  input  logic                 apBit,
  input  logic [2:0]           blCode,
  input  logic [NUM_BANKS-1:0] bankOpen,
  output ctrlStrobe_t          stb
);

  logic [3:0] cmdCode;
  cmdKind_e   kind;
  logic       targetOpen;
  logic       anyOpen;
  logic       blOk;

  assign cmdCode    = {csN, rasN, casN, weN};
  assign targetOpen = bankOpen[ba];
  assign anyOpen    = |bankOpen;
  assign blOk       = (blCode == 3'b001) || (blCode == 3'b010) || (blCode == 3'b011);

  always_comb begin
    unique casez (cmdCode)
      4'b1???: kind = KIND_NONE;
      4'b0011: kind = KIND_ACT;
      4'b0101: kind = KIND_RD;
      4'b0100: kind = KIND_WR;
      4'b0010: kind = KIND_PRE;
      4'b0001: kind = KIND_REF;
      4'b0000: kind = KIND_LMR;
      4'b0110: kind = KIND_BST;
      default: kind = KIND_NONE;
    endcase
  end

  always_comb begin
    stb       = '0;
    stb.kind  = kind;
    stb.valid = (kind != KIND_NONE);
    case (kind)
      KIND_ACT: begin
        stb.illegal    = targetOpen;
        stb.openBank   = !targetOpen;
        stb.captureRow = !targetOpen;
      end
      KIND_RD, KIND_WR: begin
        stb.illegal    = !targetOpen;
        stb.captureCol = targetOpen;
        stb.autoPre    = apBit;
        stb.closeBank  = targetOpen && apBit;
      end
      KIND_PRE: begin
        stb.closeAll  = apBit;
        stb.closeBank = !apBit;
      end
      KIND_REF: begin
        stb.illegal = anyOpen;
      end
      KIND_LMR: begin
        if (anyOpen) begin
          stb.illegal = 1'b1;
        end else if (ba == 2'b00) begin
          stb.illegal  = !blOk;
          stb.loadBase = blOk;
        end else if (ba == 2'b01) begin
          stb.loadExt = 1'b1;
        end else begin
          stb.illegal = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sdram_cmd_dpath.sv
module sdram_cmd_dpath
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 11,
  parameter int AP_BIT = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          stb,
  input  logic [BA_W-1:0]      ba,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 cmdValid,
  output cmdKind_e             cmdKind,
  output logic [BA_W-1:0]      cmdBank,
  output logic [ROW_W-1:0]     cmdRow,
  output logic [COL_W-1:0]     cmdCol,
  output logic                 autoPre,
  output logic                 preAll,
  output logic                 illegal,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [3:0]           burstLen,
  output logic                 burstInterleave,
  output logic [2:0]           casLat,
  output logic [ADDR_W-1:0]    extMode
);

  logic [COL_W-1:0] colField;
  logic [3:0]       blValue;

  // column skips the auto-precharge bit when it is wider than the bits below it
  generate
    if (COL_W > AP_BIT) begin : g_colSplit
      assign colField = {addr[COL_W:AP_BIT+1], addr[AP_BIT-1:0]};
    end else begin : g_colFlat
      assign colField = addr[COL_W-1:0];
    end
  endgenerate

  always_comb begin
    case (addr[2:0])
      3'b010:  blValue = 4'd4;
      3'b011:  blValue = 4'd8;
      default: blValue = 4'd2;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdKind  <= KIND_NONE;
      cmdBank  <= '0;
      autoPre  <= 1'b0;
      preAll   <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      cmdValid <= stb.valid;
      cmdKind  <= stb.kind;
      cmdBank  <= stb.valid ? ba : cmdBank;
      autoPre  <= stb.autoPre;
      preAll   <= stb.closeAll;
      illegal  <= stb.illegal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdRow <= '0;
      cmdCol <= '0;
    end else begin
      if (stb.captureRow) cmdRow <= addr[ROW_W-1:0];
      if (stb.captureCol) cmdCol <= colField;
    end
  end

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bankOpen[b] <= 1'b0;
        end else if (stb.closeAll) begin
          bankOpen[b] <= 1'b0;
        end else if (ba == BA_W'(b)) begin
          if (stb.openBank)       bankOpen[b] <= 1'b1;
          else if (stb.closeBank) bankOpen[b] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstLen        <= 4'd2;
      burstInterleave <= 1'b0;
      casLat          <= 3'b010;
      extMode         <= '0;
    end else begin
      if (stb.loadBase) begin
        burstLen        <= blValue;
        burstInterleave <= addr[3];
        casLat          <= addr[6:4];
      end
      if (stb.loadExt) extMode <= addr;
    end
  end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 11,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmdValid,
  output logic [2:0]        cmdKind,
  output logic [1:0]        cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol,
  output logic              autoPre,
  output logic              preAll,
  output logic              illegal,
  output logic [3:0]        bankOpen,
  output logic [3:0]        burstLen,
  output logic              burstInterleave,
  output logic [2:0]        casLat,
  output logic [ADDR_W-1:0] extMode
);

  ctrlStrobe_t stb;
  cmdKind_e    kindQ;

  sdram_cmd_ctrl u_ctrl (
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .ba       (ba),
    .apBit    (addr[AP_BIT]),
    .blCode   (addr[2:0]),
    .bankOpen (bankOpen),
    .stb      (stb)
  );

  sdram_cmd_dpath #(
    .ADDR_W (ADDR_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .AP_BIT (AP_BIT)
  ) u_dpath (
    .clk             (clk),
    .rstN            (rstN),
    .stb             (stb),
    .ba              (ba),
    .addr            (addr),
    .cmdValid        (cmdValid),
    .cmdKind         (kindQ),
    .cmdBank         (cmdBank),
    .cmdRow          (cmdRow),
    .cmdCol          (cmdCol),
    .autoPre         (autoPre),
    .preAll          (preAll),
    .illegal         (illegal),
    .bankOpen        (bankOpen),
    .burstLen        (burstLen),
    .burstInterleave (burstInterleave),
    .casLat          (casLat),
    .extMode         (extMode)
  );

  assign cmdKind = kindQ;

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       rasN,
  input logic       casN,
  input logic       weN,
  input logic [1:0] ba,
  input logic       apBit,
  input logic       cmdValid,
  input logic [1:0] cmdBank,
  input logic       autoPre,
  input logic       illegal,
  input logic [3:0] bankOpen,
  input logic [3:0] burstLen
);

  logic isAct, isRdWr, isPre, isRef;
  assign isAct  = !csN && !rasN &&  casN &&  weN;
  assign isRdWr = !csN &&  rasN && !casN;
  assign isPre  = !csN && !rasN &&  casN && !weN;
  assign isRef  = !csN && !rasN && !casN &&  weN;

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (!cmdValid && $stable(bankOpen))); // R2

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (isAct && !bankOpen[ba]) |=> (bankOpen[$past(ba)] && !illegal)); // R4

  AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (isPre && apBit) |=> (bankOpen == 4'b0000)); // R5

  AST_AUTOPRE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !illegal && autoPre) |-> !bankOpen[cmdBank]); // R6

  AST_DOUBLE_ACT: assert property (@(posedge clk) disable iff (!rstN)
    (isAct && bankOpen[ba]) |=> (illegal && $stable(bankOpen))); // R7

  AST_ACCESS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (isRdWr && !bankOpen[ba]) |=> (illegal && $stable(bankOpen))); // R8

  AST_REF_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (isRef && (bankOpen != 4'b0000)) |=> illegal); // R9

  AST_BURST_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (burstLen == 4'd2) || (burstLen == 4'd4) || (burstLen == 4'd8)); // R10

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN),
  .ba       (ba),
  .apBit    (addr[AP_BIT]),
  .cmdValid (cmdValid),
  .cmdBank  (cmdBank),
  .autoPre  (autoPre),
  .illegal  (illegal),
  .bankOpen (bankOpen),
  .burstLen (burstLen)
);

// File: tb/sdram_cmd_tracker_bench.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_bench;

  localparam int ADDR_W = 13;
  localparam int ROW_W  = 13;
  localparam int COL_W  = 11;

  localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_PRE = 4'b0010, C_REF = 4'b0001, C_LMR = 4'b0000,
                         C_NOP = 4'b0111, C_BST = 4'b0110;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] code = C_NOP;
  logic [1:0] ba = '0;
  logic [ADDR_W-1:0] addr = '0;

  logic              cmdValid, autoPre, preAll, illegal, burstInterleave;
  logic [2:0]        cmdKind, casLat;
  logic [1:0]        cmdBank;
  logic [ROW_W-1:0]  cmdRow;
  logic [COL_W-1:0]  cmdCol;
  logic [3:0]        bankOpen, burstLen;
  logic [ADDR_W-1:0] extMode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_tracker u_sdram_cmd_tracker (
    .clk(clk), .rstN(rstN),
    .csN(code[3]), .rasN(code[2]), .casN(code[1]), .weN(code[0]),
    .ba(ba), .addr(addr),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdBank(cmdBank),
    .cmdRow(cmdRow), .cmdCol(cmdCol), .autoPre(autoPre), .preAll(preAll),
    .illegal(illegal), .bankOpen(bankOpen), .burstLen(burstLen),
    .burstInterleave(burstInterleave), .casLat(casLat), .extMode(extMode)
  );

  // {reqNum, code, ba, addr, expValid, expKind, expIllegal, expOpen}
  localparam int NV = 16;
  localparam logic [31:0] VEC [NV] = '{
    {4'd2,  C_NOP,   2'd0, 13'h0000, 1'b0, 3'd0, 1'b0, 4'b0000}, // R2 nop
    {4'd2,  4'b1011, 2'd0, 13'h0000, 1'b0, 3'd0, 1'b0, 4'b0000}, // R2 deselect
    {4'd4,  C_ACT,   2'd1, 13'h00AB, 1'b1, 3'd1, 1'b0, 4'b0010}, // R4
    {4'd7,  C_ACT,   2'd1, 13'h0011, 1'b1, 3'd1, 1'b1, 4'b0010}, // R7
    {4'd8,  C_RD,    2'd2, 13'h0000, 1'b1, 3'd2, 1'b1, 4'b0010}, // R8
    {4'd6,  C_WR,    2'd1, 13'h0005, 1'b1, 3'd3, 1'b0, 4'b0010}, // R6
    {4'd4,  C_ACT,   2'd3, 13'h0100, 1'b1, 3'd1, 1'b0, 4'b1010}, // R4
    {4'd9,  C_REF,   2'd0, 13'h0000, 1'b1, 3'd5, 1'b1, 4'b1010}, // R9
    {4'd5,  C_PRE,   2'd1, 13'h0000, 1'b1, 3'd4, 1'b0, 4'b1000}, // R5
    {4'd6,  C_RD,    2'd3, 13'h0400, 1'b1, 3'd2, 1'b0, 4'b0000}, // R6
    {4'd4,  C_ACT,   2'd0, 13'h0001, 1'b1, 3'd1, 1'b0, 4'b0001}, // R4
    {4'd4,  C_ACT,   2'd2, 13'h0002, 1'b1, 3'd1, 1'b0, 4'b0101}, // R4
    {4'd5,  C_PRE,   2'd0, 13'h0400, 1'b1, 3'd4, 1'b0, 4'b0000}, // R5
    {4'd3,  C_BST,   2'd0, 13'h0000, 1'b1, 3'd7, 1'b0, 4'b0000}, // R3
    {4'd3,  C_REF,   2'd0, 13'h0000, 1'b1, 3'd5, 1'b0, 4'b0000}, // R3
    {4'd2,  4'b1011, 2'd2, 13'h0000, 1'b0, 3'd0, 1'b0, 4'b0000}  // R2
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, returns at the next falling edge (one rising edge between)
  task automatic issue(input logic [3:0] c, input logic [1:0] b, input logic [ADDR_W-1:0] a);
    code = c; ba = b; addr = a;
    @(negedge clk);
    code = C_NOP; ba = '0; addr = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12", "valid/illegal/kind", {29'd0, cmdValid, illegal, autoPre}, 32'd0);
    check("R12", "bankOpen/preAll", {27'd0, preAll, bankOpen}, 32'd0);
    check("R12", "burstLen", {28'd0, burstLen}, 32'd2);
    check("R12", "casLat/interleave", {28'd0, casLat, burstInterleave}, {28'd0, 3'b010, 1'b0});
    check("R12", "kind/bank/row/col", {cmdKind, cmdBank, cmdRow, cmdCol}, 32'd0);
    check("R12", "extMode", {19'd0, extMode}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      string rq;
      v = VEC[i];
      issue(v[27:24], v[23:22], v[21:9]);
      rq = $sformatf("R%0d", v[31:28]);
      check(rq, $sformatf("vector %0d (R1/R3 decode)", i),
            {23'd0, cmdValid, cmdKind, illegal, bankOpen}, {23'd0, v[8:0]});
    end

    // R10 base mode: BL code 011 -> 8, interleave 1, CAS field 011
    issue(C_LMR, 2'd0, 13'h003B);
    check("R10", "burstLen after load", {28'd0, burstLen}, 32'd8);
    check("R10", "cas/interleave/illegal", {27'd0, casLat, burstInterleave, illegal}, {27'd0, 3'b011, 1'b1, 1'b0});
    // R10 bad burst code 101 rejected
    issue(C_LMR, 2'd0, 13'h0025);
    check("R10", "bad BL code", {24'd0, illegal, burstLen, casLat}, {24'd0, 1'b1, 4'd8, 3'b011});
    // R11 extended register
    issue(C_LMR, 2'd1, 13'h1002);
    check("R11", "extMode load", {18'd0, illegal, extMode}, {18'd0, 1'b0, 13'h1002});
    issue(C_LMR, 2'd2, 13'h0055);
    check("R11", "reserved select", {18'd0, illegal, extMode}, {18'd0, 1'b1, 13'h1002});
    // R4 row capture
    issue(C_ACT, 2'd0, 13'h1ABC);
    check("R4", "row/open", {15'd0, cmdRow, bankOpen}, {15'd0, 13'h1ABC, 4'b0001});
    // R9 load mode while open
    issue(C_LMR, 2'd0, 13'h0021);
    check("R9", "load while open", {27'd0, illegal, burstLen}, {27'd0, 1'b1, 4'd8});
    // R6 column with A11 and no auto precharge
    issue(C_WR, 2'd0, 13'h0BFF);
    check("R6", "col/autoPre/open", {16'd0, cmdCol, autoPre, bankOpen}, {16'd0, 11'h7FF, 1'b0, 4'b0001});
    issue(C_RD, 2'd0, 13'h0403);
    check("R6", "autoPre closes", {16'd0, cmdCol, autoPre, bankOpen}, {16'd0, 11'h003, 1'b1, 4'b0000});
    // R5 single versus all
    issue(C_ACT, 2'd1, 13'h0001);
    issue(C_ACT, 2'd2, 13'h0002);
    issue(C_PRE, 2'd2, 13'h0000);
    check("R5", "single precharge", {27'd0, preAll, bankOpen}, {27'd0, 1'b0, 4'b0010});
    issue(C_PRE, 2'd3, 13'h0400);
    check("R5", "precharge all", {27'd0, preAll, bankOpen}, {27'd0, 1'b1, 4'b0000});
    // R2 deselect carrying a load-mode pattern changes nothing; R1 strobe lasts one cycle
    issue(4'b1000, 2'd0, 13'h0022);
    check("R2", "deselect no load", {27'd0, cmdValid, burstLen}, {27'd0, 1'b0, 4'd8});
    issue(C_BST, 2'd0, 13'h0000);
    @(negedge clk);
    check("R1", "strobe one cycle", {31'd0, cmdValid}, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule